// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block generates programmed-I/O read and write strobes for four drives on two IDE channels. Each cycle has three phases in a fixed order: address setup, with no strobe; active, with the read or write strobe high; and recovery, with the strobe low again. The length of each phase, in clocks, comes from a small byte-wide register file. Drives 0 and 1 on the primary channel each have their own timing registers. Drives 2 and 3 on the secondary channel share one pair.

A host writes timing values through a simple register port. It then starts a cycle by raising `reqValid` for one clock, with a drive index, a read/write flag and a flag that marks an access to the command register block. The block latches the phase lengths when it accepts the request. It keeps `busy` high while the cycle runs and pulses `done` in the last recovery clock. A chip-revision input lengthens every recovery phase by one clock when its value is above 1.

Register map, by address: 0 command-block timing, 1 drive-0 setup, 2 drive-0 active/recovery, 3 drive-1 setup, 4 drive-1 active/recovery, 5 shared secondary setup, 6 shared secondary active/recovery, 7 control, 8 burst size.

Top module: `ide_pio_timer`

## Requirements
- R1: After reset, addresses 0 to 7 read 0x00 and address 8 (burst size, 512-byte burst) reads 0x40. `busy`, `done`, `rdStrobe` and `wrStrobe` are low.
- R2: A write to addresses 0 to 8 stores the full byte, and reading that address returns it. The stored bits include the prefetch-disable flags: control bits 6 and 7 for drives 0 and 1, shared setup bits 2 and 3 for drives 2 and 3. Addresses 9 to 15 read 0x00.
- R3: Bits 7:6 of a setup register select the number of setup clocks: 00 gives 4, 10 gives 3, 01 gives 2, 11 gives 5. Bits 5:0 have no effect on timing. No strobe is asserted during setup.
- R4: The upper nibble of an active/recovery register gives the number of active clocks. A value of 0 means 16, and a value of 1 is raised to 2. The active strobe is `wrStrobe` when `reqWrite` was 1 at request time, and `rdStrobe` otherwise.
- R5: The lower nibble gives the number of recovery clocks, with 0 meaning 16. When `chipRev` is above 1, recovery lasts one clock more.
- R6: Drive 0 uses addresses 1 and 2, drive 1 uses addresses 3 and 4, and drives 2 and 3 both use addresses 5 and 6.
- R7: When `reqCmd` is 1 and address 0 holds 0, the cycle uses 4 setup, 16 active and 16 recovery clocks (plus the revision clock). When address 0 is nonzero, it uses the drive's own timing.
- R8: `done` is high for exactly one clock, the last recovery clock. `busy` falls on the clock after it.
- R9: A request made while `busy` is high is ignored. It neither changes the running cycle nor starts another one afterwards.
- R10: A request for drive 2 or 3 is ignored while control bit 3 (secondary enable) is clear.
- R11: `rdStrobe` and `wrStrobe` are never high together, and neither is high outside a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipRev | input | 2 | Chip revision; above 1 adds a recovery clock |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| reqValid | input | 1 | Cycle request, one clock |
| reqDrive | input | 2 | Target drive index 0 to 3 |
| reqWrite | input | 1 | 1 for a write cycle, 0 for a read cycle |
| reqCmd | input | 1 | Cycle targets the command register block |
| rdStrobe | output | 1 | Read strobe, high during the active phase of a read |
| wrStrobe | output | 1 | Write strobe, high during the active phase of a write |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last recovery clock of a cycle |

## Verification
The assertions assume the timing registers are not rewritten while a cycle runs; once the cycle has started, only the latched copy is used. They also assume `chipRev` holds a settled value at each request. The stimulus writes registers only while `busy` is low and changes `chipRev` only between cycles. It also raises requests while a cycle runs, and for the secondary drives with the channel disabled, to show they are ignored. The sweep covers every setup code against every active and recovery nibble on drive 0. It varies the revision and the direction from one vector to the next, and fills the unused setup bits with changing values.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int REG_AW   = 4;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 5;
  localparam int REV_W    = 2;
  localparam int NUM_REGS = 9;

  localparam int A_CMDTIM  = 0;
  localparam int A_SETUP0  = 1;
  localparam int A_RWTIM0  = 2;
  localparam int A_SETUP1  = 3;
  localparam int A_RWTIM1  = 4;
  localparam int A_SETUPSH = 5;
  localparam int A_RWTIMSH = 6;
  localparam int A_CTRL    = 7;
  localparam int A_BURST   = 8;

  localparam int SEC_EN_BIT = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_t;

  typedef struct packed {
    logic loadReq;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [CNT_W-1:0] setupClk;
    logic [CNT_W-1:0] activeClk;
    logic [CNT_W-1:0] recovClk;
  } timing_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx);
    return (idx == A_BURST) ? DATA_W'(8'h40) : '0;
  endfunction

  // non-monotonic two-bit setup code
  function automatic logic [CNT_W-1:0] decodeSetup(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(4);
      2'b10:   return CNT_W'(3);
      2'b01:   return CNT_W'(2);
      default: return CNT_W'(5);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decodeActive(input logic [3:0] nib);
    if (nib == 4'd0)      return CNT_W'(16);
    else if (nib < 4'd2)  return CNT_W'(2);
    else                  return CNT_W'(nib);
  endfunction

  function automatic logic [CNT_W-1:0] decodeRecov(input logic [3:0] nib,
                                                   input logic [REV_W-1:0] rev);
    logic [CNT_W-1:0] base;
    base = (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
    return (rev > REV_W'(1)) ? base + CNT_W'(1) : base;
  endfunction
endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs
  import ide_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [1:0]        reqDrive,
  input  logic              reqCmd,
  input  logic [REV_W-1:0]  chipRev,
  input  ctrlStrobe_t       strobes,
  output logic              secEnable,
  output timing_t           curTiming
);
  logic [DATA_W-1:0] regFile [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= resetValue(g);
      else if (regWe && regAddr == REG_AW'(g))
        regFile[g] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (regAddr == REG_AW'(i)) regRdata = regFile[i];
  end

  assign secEnable = regFile[A_CTRL][SEC_EN_BIT];

  logic [DATA_W-1:0] setupByte;
  logic [DATA_W-1:0] rwByte;
  timing_t           nextTiming;

  always_comb begin
    case (reqDrive)
      2'd0:    begin setupByte = regFile[A_SETUP0];  rwByte = regFile[A_RWTIM0];  end
      2'd1:    begin setupByte = regFile[A_SETUP1];  rwByte = regFile[A_RWTIM1];  end
      default: begin setupByte = regFile[A_SETUPSH]; rwByte = regFile[A_RWTIMSH]; end
    endcase
    if (reqCmd && regFile[A_CMDTIM] == '0) begin
      nextTiming.setupClk  = decodeSetup(2'b00);
      nextTiming.activeClk = decodeActive(4'd0);
      nextTiming.recovClk  = decodeRecov(4'd0, chipRev);
    end else begin
      nextTiming.setupClk  = decodeSetup(setupByte[7:6]);
      nextTiming.activeClk = decodeActive(rwByte[7:4]);
      nextTiming.recovClk  = decodeRecov(rwByte[3:0], chipRev);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTiming.setupClk  <= CNT_W'(4);
      curTiming.activeClk <= CNT_W'(16);
      curTiming.recovClk  <= CNT_W'(16);
    end else if (strobes.loadReq) begin
      curTiming <= nextTiming;
    end
  end

  // R10
  sec_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadReq && reqDrive[1] |-> secEnable);
  // R4
  active_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    curTiming.activeClk >= CNT_W'(2) && curTiming.activeClk <= CNT_W'(16));
  // R5
  recov_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curTiming.recovClk >= CNT_W'(1) && curTiming.recovClk <= CNT_W'(17));
  // R3
  setup_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curTiming.setupClk >= CNT_W'(2) && curTiming.setupClk <= CNT_W'(5));
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqDrive,
  input  logic        reqWrite,
  input  logic        secEnable,
  input  timing_t     curTiming,
  output ctrlStrobe_t strobes,
  output logic        rdStrobe,
  output logic        wrStrobe,
  output logic        busy,
  output logic        done
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             isWrite;
  logic             accept;

  assign accept = reqValid && (phase == PH_IDLE) && (!reqDrive[1] || secEnable);
  assign strobes.loadReq = accept;

  always_comb begin
    case (phase)
      PH_SETUP:  limit = curTiming.setupClk;
      PH_ACTIVE: limit = curTiming.activeClk;
      PH_RECOV:  limit = curTiming.recovClk;
      default:   limit = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (accept) begin
        phase   <= PH_SETUP;
        cnt     <= CNT_W'(1);
        isWrite <= reqWrite;
      end
    end else if (cnt == limit) begin
      cnt <= CNT_W'(1);
      case (phase)
        PH_SETUP:  phase <= PH_ACTIVE;
        PH_ACTIVE: phase <= PH_RECOV;
        default:   phase <= PH_IDLE;
      endcase
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign done     = (phase == PH_RECOV) && (cnt == limit);
  assign rdStrobe = (phase == PH_ACTIVE) && !isWrite;
  assign wrStrobe = (phase == PH_ACTIVE) && isWrite;

  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStrobe, wrStrobe}) && (busy || !(rdStrobe || wrStrobe)));
  // R9
  no_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy && $stable(isWrite));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cnt >= CNT_W'(1) && cnt <= limit);
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REV_W-1:0]  chipRev,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              reqValid,
  input  logic [1:0]        reqDrive,
  input  logic              reqWrite,
  input  logic              reqCmd,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              busy,
  output logic              done
);
  ctrlStrobe_t strobes;
  timing_t     curTiming;
  logic        secEnable;

  ide_pio_regs u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .reqDrive  (reqDrive),
    .reqCmd    (reqCmd),
    .chipRev   (chipRev),
    .strobes   (strobes),
    .secEnable (secEnable),
    .curTiming (curTiming)
  );

  ide_pio_seq u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqDrive  (reqDrive),
    .reqWrite  (reqWrite),
    .secEnable (secEnable),
    .curTiming (curTiming),
    .strobes   (strobes),
    .rdStrobe  (rdStrobe),
    .wrStrobe  (wrStrobe),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: tb/ide_pio_timer_test.sv
module ide_pio_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] chipRev = 2'd1;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       reqValid = 1'b0;
  logic [1:0] reqDrive = '0;
  logic       reqWrite = 1'b0;
  logic       reqCmd = 1'b0;
  logic       rdStrobe, wrStrobe, busy, done;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  ide_pio_timer uut (
    .clk(clk), .rstN(rstN), .chipRev(chipRev),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .reqValid(reqValid), .reqDrive(reqDrive), .reqWrite(reqWrite), .reqCmd(reqCmd),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int val);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'(addr); regWdata = 8'(val);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input int addr, output int val);
    @(negedge clk);
    regAddr = 4'(addr);
    #1 val = int'(regRdata);
  endtask

  function automatic int expSetup(input int code);
    case (code)
      0: return 4;
      2: return 3;
      1: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic int expActive(input int nib);
    if (nib == 0) return 16;
    if (nib < 2) return 2;
    return nib;
  endfunction

  function automatic int expRecov(input int nib, input int rev);
    return ((nib == 0) ? 16 : nib) + ((rev > 1) ? 1 : 0);
  endfunction

  // issues a request and measures phase lengths at the ports
  task automatic runCycle(input int drv, input bit wr, input bit cmd,
                          output int s, output int a, output int r, output bit flagsOk);
    int nDone, lastDone, guard;
    s = 0; a = 0; r = 0; flagsOk = 1; nDone = 0; lastDone = 0; guard = 0;
    @(negedge clk);
    reqValid = 1'b1; reqDrive = 2'(drv); reqWrite = wr; reqCmd = cmd;
    @(negedge clk);
    reqValid = 1'b0; reqCmd = 1'b0;
    while (busy && guard < 200) begin
      if ((wr && rdStrobe) || (!wr && wrStrobe)) flagsOk = 0;
      if (rdStrobe || wrStrobe) begin
        a++;
        if (r > 0) flagsOk = 0;
      end else if (a == 0) s++;
      else r++;
      lastDone = int'(done);
      if (done) nDone++;
      guard++;
      @(negedge clk);
    end
    if (nDone != 1 || lastDone != 1) flagsOk = 0;
  endtask

  task automatic checkTiming(input string req, input int s, input int a, input int r,
                             input bit ok, input int es, input int ea, input int er);
    nChecks++;
    if (!(ok && s == es && a == ea && r == er)) begin
      nFails++;
      $display("FAIL %s: actual %0d/%0d/%0d flags=%0d expected %0d/%0d/%0d flags=1",
               req, s, a, r, ok, es, ea, er);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int v, s, a, r;
    bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check(!busy && !done && !rdStrobe && !wrStrobe, "R1 outputs", int'(busy), 0);
    for (int i = 0; i < 9; i++) begin
      readReg(i, v);
      check(v == ((i == 8) ? 8'h40 : 0), "R1 reg", v, (i == 8) ? 8'h40 : 0);
    end

    // R2 write and read back, unmapped reads zero
    for (int i = 0; i < 9; i++) writeReg(i, 8'hA0 + i * 7);
    for (int i = 0; i < 9; i++) begin
      readReg(i, v);
      check(v == 8'hA0 + i * 7, "R2 readback", v, 8'hA0 + i * 7);
    end
    writeReg(7, 8'hC8);
    readReg(7, v);
    check(v == 8'hC8, "R2 prefetch bits", v, 8'hC8);
    for (int i = 9; i < 16; i++) begin
      readReg(i, v);
      check(v == 0, "R2 unmapped", v, 0);
    end
    writeReg(0, 0);

    // R3 R4 R5 sweep on drive 0
    for (int code = 0; code < 4; code++)
      for (int an = 0; an < 16; an++)
        for (int rn = 0; rn < 16; rn++) begin
          int rev;
          rev = ((code + an + rn) % 2 == 1) ? 2 : 1;
          chipRev = 2'(rev);
          writeReg(1, (code << 6) | ((an * 5 + rn) & 6'h3f));
          writeReg(2, (an << 4) | rn);
          runCycle(0, rn[0], 1'b0, s, a, r, ok);
          checkTiming("R3 R4 R5 sweep", s, a, r, ok,
                      expSetup(code), expActive(an), expRecov(rn, rev));
        end

    // R6 drive register mapping
    chipRev = 2'd1;
    writeReg(1, 8'h40); writeReg(2, 8'h23);
    writeReg(3, 8'h80); writeReg(4, 8'h45);
    writeReg(5, 8'hC0); writeReg(6, 8'h67);
    writeReg(7, 8'h08);
    runCycle(0, 1'b1, 1'b0, s, a, r, ok);
    checkTiming("R6 drive0", s, a, r, ok, 2, 2, 3);
    runCycle(1, 1'b0, 1'b0, s, a, r, ok);
    checkTiming("R6 drive1", s, a, r, ok, 3, 4, 5);
    runCycle(2, 1'b1, 1'b0, s, a, r, ok);
    checkTiming("R6 drive2", s, a, r, ok, 5, 6, 7);
    runCycle(3, 1'b0, 1'b0, s, a, r, ok);
    checkTiming("R6 drive3", s, a, r, ok, 5, 6, 7);

    // R7 command block timing
    runCycle(0, 1'b0, 1'b1, s, a, r, ok);
    checkTiming("R7 cmd slow", s, a, r, ok, 4, 16, 16);
    chipRev = 2'd2;
    runCycle(2, 1'b1, 1'b1, s, a, r, ok);
    checkTiming("R7 cmd slow rev", s, a, r, ok, 4, 16, 17);
    chipRev = 2'd1;
    writeReg(0, 8'h01);
    runCycle(0, 1'b0, 1'b1, s, a, r, ok);
    checkTiming("R7 cmd nonzero", s, a, r, ok, 2, 2, 3);
    writeReg(0, 0);

    // R9 request during a cycle is ignored
    begin
      int total;
      bit wrSeen;
      total = 0; wrSeen = 0;
      writeReg(1, 8'h00); writeReg(2, 8'h88);
      @(negedge clk);
      reqValid = 1'b1; reqDrive = 2'd0; reqWrite = 1'b0;
      @(negedge clk);
      reqValid = 1'b0;
      while (busy && total < 200) begin
        if (wrStrobe) wrSeen = 1;
        if (total == 2) begin reqValid = 1'b1; reqDrive = 2'd1; reqWrite = 1'b1; end
        if (total == 3) reqValid = 1'b0;
        if (done) reqValid = 1'b0;
        total++;
        @(negedge clk);
      end
      check(total == 20 && !wrSeen, "R9 running cycle kept", total, 20);
      @(negedge clk);
      check(!busy, "R9 no queued cycle", int'(busy), 0);
    end

    // R8 done single pulse already checked in flags; explicit check after done
    runCycle(0, 1'b1, 1'b0, s, a, r, ok);
    check(ok && !busy && !done, "R8 done pulse then idle", int'(ok), 1);

    // R10 secondary disabled
    writeReg(7, 8'h00);
    for (int d = 2; d < 4; d++) begin
      @(negedge clk);
      reqValid = 1'b1; reqDrive = 2'(d);
      @(negedge clk);
      reqValid = 1'b0;
      check(!busy, "R10 secondary disabled", int'(busy), 0);
      @(negedge clk);
      check(!busy && !rdStrobe && !wrStrobe, "R11 idle strobes", int'(busy), 0);
    end
    writeReg(7, 8'h08);
    runCycle(3, 1'b0, 1'b0, s, a, r, ok);
    checkTiming("R10 secondary enabled", s, a, r, ok, 5, 6, 7);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule